// File: doc/BRIEF.md
# Nonvolatile Memory Command Launch and Status Registers

This block holds the status byte and the fault byte that a CPU uses to start and supervise commands on a nonvolatile memory controller. Software writes a one to the completion flag of the status byte to start a command. The block either passes a one-cycle launch pulse to the controller or refuses the launch. It refuses when an earlier access error or protection violation is still pending, or when the controller flags a violation at that moment. When the controller reports that it is done, the completion flag returns to one and the controller's two-bit result code is latched into the status byte.

A second byte holds two sticky fault flags, one for single-bit faults and one for double-bit faults, which the controller raises with pulses. Every error flag in both bytes is cleared by writing a one to it, and writing a zero leaves it unchanged. Reads are combinational from the address. The interrupt line is a level that is high while its enable input is set and the completion flag is one.

Top module: `nvm_cmd_status`

## Requirements
- R1: After a synchronous active-low reset, the status byte reads 0x80, the fault byte reads 0x00 and the launch output is 0.
- R2: The status byte sits at offset 0x6 with this layout: bit 7 is the completion flag, bit 5 the access error, bit 4 the protection violation and bit 3 the busy indication. Bits 1:0 hold the result code, and bits 6 and 2 read 0.
- R3: A write with bit 7 set, made while the completion flag is 1, no error is pending and no violation input is high, gives these results in the following cycle: the launch output is 1 for exactly one cycle, the completion flag is 0 and the result code is 00.
- R4: While the access error or the protection violation is pending, a write with bit 7 set leaves the completion flag at 1 and gives no launch pulse. The flags are checked as they stood before the write.
- R5: A launch attempt allowed by R4 that arrives with mc_viol high sets the access error. One that arrives with mc_prot high sets the protection violation. In both cases the completion flag reads 1 in the next cycle and no launch pulse is given.
- R6: When mc_done is high while the completion flag is 0, the flag reads 1 in the next cycle and the result code holds the value that mc_err had in the done cycle.
- R7: The busy bit equals mc_busy while the completion flag is 0 and reads 0 while the flag is 1.
- R8: Writing 1 to bit 5 or bit 4 of the status byte clears that flag. Writing 0 to either bit has no effect.
- R9: The fault byte sits at offset 0x7. Bit 1 is the double-bit flag, set by fault_dbl, and bit 0 is the single-bit flag, set by fault_sgl. Each flag is cleared by writing 1 to its bit, and a set pulse wins over a clear in the same cycle. Bits 7:2 read 0.
- R10: irq is 1 exactly when irq_en is 1 and the completion flag is 1.
- R11: Writes to other offsets change nothing. A write with bit 7 set while a command is running gives no launch pulse, and reads from other offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt level |
| mc_launch | output | 1 | One-cycle command start pulse to the controller |
| mc_busy | input | 1 | Controller active |
| mc_done | input | 1 | Controller finished the command |
| mc_viol | input | 1 | Command sequence violation at launch |
| mc_prot | input | 1 | Protected address at launch |
| mc_err | input | 2 | Result code, valid with mc_done |
| fault_sgl | input | 1 | Single-bit fault pulse |
| fault_dbl | input | 1 | Double-bit fault pulse |

## Verification
A wrong internal state shows up at the ports within one cycle of the write or controller event that should have changed it. A completion flag stuck at 0 holds irq low and blocks every later launch. A pending error that is lost lets a refused launch produce an mc_launch pulse on the next edge. A result code that is never cleared or never captured shows in the low status bits as soon as they are read back. Every check of this kind reads the register byte or the launch pin in the cycle right after the edge that should have acted.

// File: rtl/nvm_stat_pkg.sv
// Package: shared widths, offsets and status bit positions for the
// command launch / status register block.
package nvm_stat_pkg;
    localparam int DATA_W  = 8;
    localparam int CODE_W  = 2;
    localparam int BIT_CC  = 7;
    localparam int BIT_ACC = 5;
    localparam int BIT_PRV = 4;
    localparam int BIT_BSY = 3;
endpackage

// File: rtl/nvm_launch_ctl.sv
// Launch control: owns the completion flag and the launch pulse.
// Assumes the error flags it sees are registered values from before
// the current write, so a write that clears an error and launches in
// the same cycle is still refused.
module nvm_launch_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic try_i,     // write of 1 to the completion flag
    input  logic block_i,   // an error is pending
    input  logic viol_i,    // violation input high during the attempt
    input  logic done_i,    // controller done
    output logic cc_o,
    output logic launch_o,
    output logic accept_o,  // launch taken this cycle
    output logic refuse_o,  // allowed attempt rejected by a violation
    output logic finish_o   // running command completes this cycle
);
    logic attempt;

    // Decide what an attempt does in this cycle.
    always_comb begin
        attempt  = try_i && cc_o && !block_i;
        accept_o = attempt && !viol_i;
        refuse_o = attempt && viol_i;
        finish_o = done_i && !cc_o;
    end

    // Completion flag and one-cycle launch pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc_o     <= 1'b1;
            launch_o <= 1'b0;
        end else begin
            launch_o <= accept_o;
            if (accept_o)
                cc_o <= 1'b0;
            else if (finish_o)
                cc_o <= 1'b1;
        end
    end

    p_launch_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |-> !cc_o);
    p_refuse_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (try_i && block_i) |=> !launch_o);
    p_done_returns_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !cc_o) |=> cc_o);
endmodule

// File: rtl/nvm_err_flags.sv
// Error flags and result code of the status byte. The access error and
// protection violation are sticky and cleared by writing 1. The result
// code is loaded on completion and zeroed on an accepted launch.
module nvm_err_flags
    import nvm_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_acc_i,
    input  logic              set_prv_i,
    input  logic              clr_acc_i,
    input  logic              clr_prv_i,
    input  logic              start_i,
    input  logic              finish_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              acc_o,
    output logic              prv_o,
    output logic [CODE_W-1:0] code_o
);
    // Sticky error flags: a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o <= 1'b0;
            prv_o <= 1'b0;
        end else begin
            acc_o <= set_acc_i || (acc_o && !clr_acc_i);
            prv_o <= set_prv_i || (prv_o && !clr_prv_i);
        end
    end

    // Result code: cleared on launch, loaded on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code_o <= '0;
        else if (start_i)
            code_o <= '0;
        else if (finish_i)
            code_o <= code_i;
    end

    p_acc_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_o && !clr_acc_i) |=> acc_o);
    p_prv_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (prv_o && !clr_prv_i) |=> prv_o);
endmodule

// File: rtl/nvm_fault_reg.sv
// Fault byte: one sticky flag per fault kind, each set by a pulse and
// cleared by writing 1. Assumes the set pulses are synchronous to clk.
module nvm_fault_reg #(
    parameter int FLT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FLT_W-1:0] set_i,
    input  logic [FLT_W-1:0] clr_i,
    output logic [FLT_W-1:0] flag_o
);
    for (genvar g = 0; g < FLT_W; g++) begin : g_cell
        // One write-1-to-clear cell.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_o[g] <= 1'b0;
            else
                flag_o[g] <= set_i[g] || (flag_o[g] && !clr_i[g]);
        end

        p_fault_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_i[g] && !clr_i[g]) |=> $stable(flag_o[g]));
    end
endmodule

// File: rtl/nvm_cmd_status.sv
// Top: register decode and read mux for the status byte and the fault
// byte, plus the interrupt level. Reads are combinational.
module nvm_cmd_status
    import nvm_stat_pkg::*;
#(
    parameter int              ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] STAT_OFS  = 4'h6,
    parameter logic [ADDR_W-1:0] FAULT_OFS = 4'h7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              irq_en,
    output logic              irq,
    output logic              mc_launch,
    input  logic              mc_busy,
    input  logic              mc_done,
    input  logic              mc_viol,
    input  logic              mc_prot,
    input  logic [CODE_W-1:0] mc_err,
    input  logic              fault_sgl,
    input  logic              fault_dbl
);
    localparam int FLT_W = 2;

    logic              wr_stat, wr_flt;
    logic              cc, acc, prv, accept, refuse, finish;
    logic [CODE_W-1:0] code;
    logic [FLT_W-1:0]  flt;

    // Write decode per register.
    always_comb begin
        wr_stat = reg_wr && (reg_addr == STAT_OFS);
        wr_flt  = reg_wr && (reg_addr == FAULT_OFS);
    end

    nvm_launch_ctl u_launch (
        .clk      (clk),
        .rst_n    (rst_n),
        .try_i    (wr_stat && reg_wdata[BIT_CC]),
        .block_i  (acc || prv),
        .viol_i   (mc_viol || mc_prot),
        .done_i   (mc_done),
        .cc_o     (cc),
        .launch_o (mc_launch),
        .accept_o (accept),
        .refuse_o (refuse),
        .finish_o (finish)
    );

    nvm_err_flags u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_acc_i (refuse && mc_viol),
        .set_prv_i (refuse && mc_prot),
        .clr_acc_i (wr_stat && reg_wdata[BIT_ACC]),
        .clr_prv_i (wr_stat && reg_wdata[BIT_PRV]),
        .start_i   (accept),
        .finish_i  (finish),
        .code_i    (mc_err),
        .acc_o     (acc),
        .prv_o     (prv),
        .code_o    (code)
    );

    nvm_fault_reg #(.FLT_W(FLT_W)) u_fault (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  ({fault_dbl, fault_sgl}),
        .clr_i  (wr_flt ? reg_wdata[FLT_W-1:0] : '0),
        .flag_o (flt)
    );

    // Read mux and interrupt level.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == STAT_OFS) begin
            reg_rdata[BIT_CC]       = cc;
            reg_rdata[BIT_ACC]      = acc;
            reg_rdata[BIT_PRV]      = prv;
            reg_rdata[BIT_BSY]      = mc_busy && !cc;
            reg_rdata[CODE_W-1:0]   = code;
        end else if (reg_addr == FAULT_OFS) begin
            reg_rdata[FLT_W-1:0]    = flt;
        end
        irq = irq_en && cc;
    end

    p_viol_refused_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && reg_wdata[BIT_CC] && cc && !acc && !prv && mc_viol)
        |=> (acc && cc && !mc_launch));
endmodule

// File: tb/nvm_cmd_status_tb_top.sv
module nvm_cmd_status_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = 4'h0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_en = 1'b1, irq, mc_launch;
    logic       mc_busy = 1'b0, mc_done = 1'b0, mc_viol = 1'b0, mc_prot = 1'b0;
    logic [1:0] mc_err = 2'b00;
    logic       fault_sgl = 1'b0, fault_dbl = 1'b0;
    int         n_cmp = 0, n_bad = 0;
    bit         ended = 1'b0;

    localparam logic [3:0] A_ST = 4'h6, A_FL = 4'h7;

    always #2 clk = ~clk;

    nvm_cmd_status dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_en(irq_en),
        .irq(irq), .mc_launch(mc_launch), .mc_busy(mc_busy),
        .mc_done(mc_done), .mc_viol(mc_viol), .mc_prot(mc_prot),
        .mc_err(mc_err), .fault_sgl(fault_sgl), .fault_dbl(fault_dbl)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic rd(input string req, input logic [3:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic finish_cmd(input logic [1:0] code);
        mc_done = 1'b1; mc_err = code;
        tick();
        mc_done = 1'b0; mc_err = 2'b00;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        // R1 reset state
        rd("R1 status", A_ST, 8'h80);
        rd("R1 fault", A_FL, 8'h00);
        chk("R1 launch", {7'd0, mc_launch}, 8'h00);
        chk("R10 irq idle", {7'd0, irq}, 8'h01);

        // R3/R6/R2 sweep over every result code
        for (int e = 0; e < 4; e++) begin
            wr(A_ST, 8'h80);
            chk("R3 launch pulse", {7'd0, mc_launch}, 8'h01);
            rd("R3 running, code cleared", A_ST, 8'h00);
            chk("R10 irq running", {7'd0, irq}, 8'h00);
            mc_busy = 1'b1;
            rd("R7 busy while running", A_ST, 8'h08);
            tick();
            chk("R3 single pulse", {7'd0, mc_launch}, 8'h00);
            finish_cmd(e[1:0]);
            mc_busy = 1'b0;
            rd("R6 code captured", A_ST, 8'h80 | e[7:0]);
        end

        // R11 launch write while running
        wr(A_ST, 8'h80);
        tick();
        wr(A_ST, 8'h80);
        chk("R11 no launch while running", {7'd0, mc_launch}, 8'h00);
        rd("R11 still running", A_ST, 8'h00);
        finish_cmd(2'b00);
        mc_busy = 1'b1;
        rd("R7 busy masked when idle", A_ST, 8'h80);
        mc_busy = 1'b0;

        // R5 violation on launch sets access error
        mc_viol = 1'b1;
        wr(A_ST, 8'h80);
        mc_viol = 1'b0;
        chk("R5 no pulse on violation", {7'd0, mc_launch}, 8'h00);
        rd("R5 access error set", A_ST, 8'hA0);
        // R4 refused while pending
        wr(A_ST, 8'h80);
        chk("R4 no pulse with access error", {7'd0, mc_launch}, 8'h00);
        rd("R4 flag unchanged", A_ST, 8'hA0);
        // R11 other offset
        wr(4'h5, 8'hFF);
        rd("R11 other offset write", A_ST, 8'hA0);
        rd("R11 other offset read", 4'h5, 8'h00);
        // R8 zero write no effect, then clear
        wr(A_ST, 8'h40);
        rd("R8 zero write", A_ST, 8'hA0);
        wr(A_ST, 8'h20);
        rd("R8 clear access error", A_ST, 8'h80);

        // R5 protection on launch
        mc_prot = 1'b1;
        wr(A_ST, 8'h80);
        mc_prot = 1'b0;
        chk("R5 no pulse on protection", {7'd0, mc_launch}, 8'h00);
        rd("R5 protection set", A_ST, 8'h90);
        // R4 clear and launch in the same write is still refused
        wr(A_ST, 8'h90);
        chk("R4 refused with clear", {7'd0, mc_launch}, 8'h00);
        rd("R8 protection cleared", A_ST, 8'h80);
        // both violations together
        mc_prot = 1'b1; mc_viol = 1'b1;
        wr(A_ST, 8'h80);
        mc_prot = 1'b0; mc_viol = 1'b0;
        rd("R5 both flags", A_ST, 8'hB0);
        wr(A_ST, 8'h30);
        rd("R8 both cleared", A_ST, 8'h80);

        // R9 exhaustive set/clear sweep of the fault byte
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 4; c++) begin
                fault_sgl = s[0]; fault_dbl = s[1];
                tick();
                fault_sgl = 1'b0; fault_dbl = 1'b0;
                wr(A_FL, 8'hFC | c[7:0]);
                rd("R9 w1c sweep", A_FL, s[7:0] & ~c[7:0]);
                wr(A_FL, 8'h03);
            end
        end
        fault_dbl = 1'b1;
        wr(A_FL, 8'h03);
        fault_dbl = 1'b0;
        rd("R9 set wins", A_FL, 8'h02);
        rd("R2 fault not in status", A_ST, 8'h80);

        // R10 sweep of enable against the completion flag
        for (int k = 0; k < 2; k++) begin
            irq_en = k[0];
            #1;
            chk("R10 irq idle", {7'd0, irq}, {7'd0, k[0]});
            wr(A_ST, 8'h80);
            chk("R10 irq running", {7'd0, irq}, 8'h00);
            finish_cmd(2'b00);
        end

        ended = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule